// File: doc/BRIEF.md
# USB Pipe Packet Buffer with Clearing

This block holds the packet data of a single USB pipe between the serial interface engine (SIE), which writes received bytes and marks the end of each packet, and a CPU port that drains completed packets byte by byte. The buffer runs either with one bank or with two banks that alternate, so that the SIE can fill one bank while the CPU empties the other.

Four ways to empty a bank are provided. A CPU-side clear pulse drops the bank the CPU is working on. An SIE-side clear pulse drops a partly written packet on the SIE side. An optional mode frees a bank by itself once its last byte has been read. A discard mode throws every completed packet away. A configuration write sets the bank size, checks it against the maximum packet size, picks single or double banking and the two automatic modes. A rejected configuration only raises an error flag.

Top module: `usb_pipe_pktbuf`

## Requirements
- R1: After reset no packet is ready, the reported length is 0, the SIE side has a free bank, the error flag is 0, banking is single, the bank size is DEPTH and both automatic modes are off.
- R2: Bytes written with `sie_wr_en` go into the SIE bank in order. `sie_eop` (alone or with a byte, which is then the last byte) makes that bank ready. While it is ready, `cpu_rd_data` shows the byte at the read position and `cpu_rd` advances it. When there is no unread byte, `cpu_rd_data` is 0 and `cpu_rd` has no effect. `cpu_pkt_len` is the byte count of the CPU bank. `cpu_pkt_rdy` is that bank's ready flag. `sie_bank_free` is 1 when the SIE bank is not ready.
- R3: A byte written when the SIE bank already holds the configured size is dropped. Any write or end-of-packet to a ready SIE bank is dropped. A bank count never exceeds the configured size.
- R4: A `cpu_clr` pulse empties the CPU bank (count 0, not ready). In double mode, if that bank was ready, the CPU side moves to the other bank.
- R5: A `sie_clr` pulse empties the SIE bank if it is not ready, and leaves the CPU bank's packet untouched. It has no effect on a ready bank.
- R6: With the clear-after-read mode on, the read of a ready packet's last byte empties that bank, with the same bank move as R4.
- R7: With the discard mode on, an end-of-packet empties the SIE bank instead of making it ready, so no packet ever becomes ready.
- R8: In double mode the SIE moves to the other bank at each kept end-of-packet. Two packets can wait, and the CPU sees them in arrival order.
- R9: A configuration write with size 0, size above DEPTH, or size below the maximum packet size sets `cfg_err` and changes nothing. Any other configuration write clears `cfg_err`, applies the settings, empties both banks and puts both sides on bank 0. Other inputs are ignored in that cycle.
- R10: A clear that hits the bank the SIE is writing in the same cycle wins: the byte and end-of-packet of that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_size | input | CNT_W (7) | Bank size in bytes |
| cfg_maxpkt | input | CNT_W (7) | Maximum packet size, used for the check |
| cfg_dbl | input | 1 | 1: two alternating banks |
| cfg_clr_after_rd | input | 1 | 1: clear a bank once its packet is read |
| cfg_discard | input | 1 | 1: discard every received packet |
| cpu_clr | input | 1 | Clear the CPU-side bank |
| sie_clr | input | 1 | Clear the SIE-side bank |
| sie_wr_en | input | 1 | SIE byte write |
| sie_wr_data | input | DW (8) | SIE byte |
| sie_eop | input | 1 | SIE end of packet |
| cpu_rd | input | 1 | CPU read strobe, advances the read position |
| cpu_rd_data | output | DW (8) | Byte at the CPU read position |
| cpu_pkt_rdy | output | 1 | CPU bank holds a complete packet |
| cpu_pkt_len | output | CNT_W (7) | Byte count of the CPU bank |
| sie_bank_free | output | 1 | SIE bank can take data |
| cfg_err | output | 1 | Last configuration write was rejected |

## Verification
Directed packets go through single banking, double banking with one and with two waiting packets, the clear-after-read mode and the discard mode. These runs separate a bank swap from a bank clear and show whether packets come out in arrival order. Clears are issued on an idle bank, on a partly written bank together with a write, and on a ready bank. This shows whether each clear hits only its own side. A long random run then mixes bytes, ends of packets, reads, both clears and valid and invalid configurations. A behavioural queue model checks every output on every cycle, so any mismatch in ownership or counts shows up where it starts.

// File: rtl/usb_pktbuf_pkg.sv
package usb_pktbuf_pkg;
    typedef struct packed {
        logic dbl;
        logic clr_after_rd;
        logic discard;
    } pb_mode_t;
endpackage

// File: rtl/pktbuf_ram.sv
module pktbuf_ram #(
    parameter int DW = 8,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pktbuf_cfg.sv
module pktbuf_cfg
    import usb_pktbuf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] cfg_size,
    input  logic [CNT_W-1:0] cfg_maxpkt,
    input  pb_mode_t         cfg_mode,
    output logic [CNT_W-1:0] size_q,
    output pb_mode_t         mode_q,
    output logic             err_q,
    output logic             apply
);
    typedef struct packed {
        logic [CNT_W-1:0] size;
        pb_mode_t         mode;
        logic             err;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic    valid;

    always_comb begin
        valid = (cfg_size >= cfg_maxpkt) && (cfg_size != '0)
              && (cfg_size <= CNT_W'(DEPTH));
        apply = cfg_wr && valid;
        st_d  = st_q;
        if (cfg_wr) begin
            st_d.err = !valid;
            if (valid) begin
                st_d.size = cfg_size;
                st_d.mode = cfg_mode;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.size <= CNT_W'(DEPTH);
            st_q.mode <= '0;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign size_q = st_q.size;
    assign mode_q = st_q.mode;
    assign err_q  = st_q.err;

    // R9: a rejected write flags an error and keeps the old size
    a_r9_bad_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && !valid |=> err_q && $stable(size_q));
endmodule

// File: rtl/usb_pipe_pktbuf.sv
module usb_pipe_pktbuf
    import usb_pktbuf_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] cfg_size,
    input  logic [CNT_W-1:0] cfg_maxpkt,
    input  logic             cfg_dbl,
    input  logic             cfg_clr_after_rd,
    input  logic             cfg_discard,
    input  logic             cpu_clr,
    input  logic             sie_clr,
    input  logic             sie_wr_en,
    input  logic [DW-1:0]    sie_wr_data,
    input  logic             sie_eop,
    input  logic             cpu_rd,
    output logic [DW-1:0]    cpu_rd_data,
    output logic             cpu_pkt_rdy,
    output logic [CNT_W-1:0] cpu_pkt_len,
    output logic             sie_bank_free,
    output logic             cfg_err
);
    // DEPTH is a power of two: a bank index is the top address bit
    localparam int IDX_W = $clog2(DEPTH);
    localparam int AW    = IDX_W + 1;

    typedef struct packed {
        logic [1:0][CNT_W-1:0] cnt;
        logic [1:0][CNT_W-1:0] rdp;
        logic [1:0]            rdy;
        logic                  cb;
        logic                  sb;
    } st_t;

    st_t              st_d, st_q;
    logic [CNT_W-1:0] size_q;
    pb_mode_t         mode_q, mode_in;
    logic             cfg_apply;
    logic             ram_we;
    logic [AW-1:0]    waddr, raddr;
    logic [DW-1:0]    ram_rdata;
    logic             sie_clr_hit, wr_ok, rd_ok, auto_clr, byte_avail;

    assign mode_in = '{dbl: cfg_dbl, clr_after_rd: cfg_clr_after_rd,
                       discard: cfg_discard};

    pktbuf_cfg #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_size   (cfg_size),
        .cfg_maxpkt (cfg_maxpkt),
        .cfg_mode   (mode_in),
        .size_q     (size_q),
        .mode_q     (mode_q),
        .err_q      (cfg_err),
        .apply      (cfg_apply)
    );

    always_comb begin
        st_d        = st_q;
        ram_we      = 1'b0;
        sie_clr_hit = 1'b0;
        wr_ok       = 1'b0;
        rd_ok       = 1'b0;
        auto_clr    = 1'b0;
        if (cfg_apply) begin
            st_d = '0;
        end else begin
            sie_clr_hit = sie_clr && !st_q.rdy[st_q.sb];
            wr_ok = (sie_wr_en || sie_eop) && !st_q.rdy[st_q.sb]
                  && !sie_clr_hit && !(cpu_clr && (st_q.cb == st_q.sb));
            if (wr_ok && sie_wr_en && (st_q.cnt[st_q.sb] < size_q)) begin
                ram_we = 1'b1;
                st_d.cnt[st_q.sb] = st_q.cnt[st_q.sb] + CNT_W'(1);
            end
            if (wr_ok && sie_eop) begin
                if (mode_q.discard) begin
                    st_d.cnt[st_q.sb] = '0;
                end else begin
                    st_d.rdy[st_q.sb] = 1'b1;
                    if (mode_q.dbl) st_d.sb = ~st_q.sb;
                end
            end
            rd_ok = cpu_rd && !cpu_clr && st_q.rdy[st_q.cb]
                  && (st_q.rdp[st_q.cb] < st_q.cnt[st_q.cb]);
            if (rd_ok) begin
                st_d.rdp[st_q.cb] = st_q.rdp[st_q.cb] + CNT_W'(1);
                auto_clr = mode_q.clr_after_rd
                         && (st_q.rdp[st_q.cb] + CNT_W'(1) == st_q.cnt[st_q.cb]);
            end
            if (cpu_clr || auto_clr) begin
                st_d.cnt[st_q.cb] = '0;
                st_d.rdp[st_q.cb] = '0;
                st_d.rdy[st_q.cb] = 1'b0;
                if (mode_q.dbl && st_q.rdy[st_q.cb]) st_d.cb = ~st_q.cb;
            end
            if (sie_clr_hit) begin
                st_d.cnt[st_q.sb] = '0;
                st_d.rdp[st_q.sb] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign waddr = {st_q.sb, st_q.cnt[st_q.sb][IDX_W-1:0]};
    assign raddr = {st_q.cb, st_q.rdp[st_q.cb][IDX_W-1:0]};

    pktbuf_ram #(.DW(DW), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (waddr),
        .wdata (sie_wr_data),
        .raddr (raddr),
        .rdata (ram_rdata)
    );

    assign byte_avail    = st_q.rdy[st_q.cb] && (st_q.rdp[st_q.cb] < st_q.cnt[st_q.cb]);
    assign cpu_rd_data   = byte_avail ? ram_rdata : '0;
    assign cpu_pkt_rdy   = st_q.rdy[st_q.cb];
    assign cpu_pkt_len   = st_q.cnt[st_q.cb];
    assign sie_bank_free = !st_q.rdy[st_q.sb];

    // R3: no bank ever holds more than the configured size
    a_r3_cnt_within_size: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt[0] <= size_q) && (st_q.cnt[1] <= size_q));

    // R4: single-bank CPU clear leaves nothing behind
    a_r4_cpu_clr_empties: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q.dbl && cpu_clr && !cfg_apply |=> !cpu_pkt_rdy && (cpu_pkt_len == '0));

    // R5: an SIE clear never disturbs a ready CPU packet
    a_r5_sie_clr_spares_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        sie_clr && cpu_pkt_rdy && !cpu_clr && !cpu_rd && !cfg_apply
        |=> cpu_pkt_rdy && $stable(cpu_pkt_len));

    // R7: discard mode never presents a packet
    a_r7_discard_never_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q.discard |-> !cpu_pkt_rdy);

    // R10: clear beats a same-cycle write on a single bank
    a_r10_clear_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q.dbl && sie_clr && !cpu_pkt_rdy && !cfg_apply |=> (cpu_pkt_len == '0));
endmodule

// File: tb/tb_usb_pipe_pktbuf.sv
`timescale 1ns/1ps
module tb_usb_pipe_pktbuf;
    localparam int DEPTH = 64;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 0, cfg_dbl = 0, cfg_clr_after_rd = 0, cfg_discard = 0;
    logic [CNT_W-1:0] cfg_size = '0, cfg_maxpkt = '0;
    logic cpu_clr = 0, sie_clr = 0, sie_wr_en = 0, sie_eop = 0, cpu_rd = 0;
    logic [7:0] sie_wr_data = '0;
    logic [7:0] cpu_rd_data;
    logic cpu_pkt_rdy, sie_bank_free, cfg_err;
    logic [CNT_W-1:0] cpu_pkt_len;

    always #2.5 clk = ~clk;

    usb_pipe_pktbuf #(.DW(8), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_size(cfg_size),
        .cfg_maxpkt(cfg_maxpkt), .cfg_dbl(cfg_dbl),
        .cfg_clr_after_rd(cfg_clr_after_rd), .cfg_discard(cfg_discard),
        .cpu_clr(cpu_clr), .sie_clr(sie_clr), .sie_wr_en(sie_wr_en),
        .sie_wr_data(sie_wr_data), .sie_eop(sie_eop), .cpu_rd(cpu_rd),
        .cpu_rd_data(cpu_rd_data), .cpu_pkt_rdy(cpu_pkt_rdy),
        .cpu_pkt_len(cpu_pkt_len), .sie_bank_free(sie_bank_free),
        .cfg_err(cfg_err)
    );

    int total = 0, bad = 0;
    bit done = 0;
    string cur = "R1";

    // behavioural model: one byte queue per bank
    logic [7:0] mq [2][$];
    int  mrd [2];
    bit  mrdy [2];
    int  mcb, msb, msize, cb, sb;
    bit  mdbl, mrc, mdisc, merr, sclr, wok, acl, oldrdy;

    task automatic mclr(int b);
        mq[b].delete();
        mrd[b]  = 0;
        mrdy[b] = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mclr(0); mclr(1);
            mcb = 0; msb = 0; msize = DEPTH;
            mdbl = 0; mrc = 0; mdisc = 0; merr = 0;
        end else if (cfg_wr && cfg_size >= cfg_maxpkt && cfg_size != 0
                     && int'(cfg_size) <= DEPTH) begin
            merr = 0; msize = int'(cfg_size);
            mdbl = cfg_dbl; mrc = cfg_clr_after_rd; mdisc = cfg_discard;
            mclr(0); mclr(1); mcb = 0; msb = 0;
        end else begin
            if (cfg_wr) merr = 1;
            cb = mcb; sb = msb; oldrdy = mrdy[cb]; acl = 0;
            sclr = sie_clr && !mrdy[sb];
            wok  = (sie_wr_en || sie_eop) && !mrdy[sb] && !sclr
                 && !(cpu_clr && cb == sb);
            if (cpu_rd && !cpu_clr && mrdy[cb] && mrd[cb] < mq[cb].size()) begin
                mrd[cb]++;
                if (mrc && mrd[cb] == mq[cb].size()) acl = 1;
            end
            if (wok) begin
                if (sie_wr_en && mq[sb].size() < msize) mq[sb].push_back(sie_wr_data);
                if (sie_eop) begin
                    if (mdisc) mq[sb].delete();
                    else begin
                        mrdy[sb] = 1;
                        if (mdbl) msb = 1 - sb;
                    end
                end
            end
            if (cpu_clr || acl) begin
                mclr(cb);
                if (mdbl && oldrdy) mcb = 1 - cb;
            end
            if (sclr) mclr(sb);
        end
    end

    task automatic cmp();
        int  elen;
        logic [7:0] edat;
        elen = mq[mcb].size();
        edat = (mrdy[mcb] && mrd[mcb] < elen) ? mq[mcb][mrd[mcb]] : 8'h00;
        total++;
        if (cpu_pkt_rdy !== mrdy[mcb] || int'(cpu_pkt_len) != elen ||
            cpu_rd_data !== edat || sie_bank_free !== !mrdy[msb] || cfg_err !== merr) begin
            bad++;
            $display("FAIL %s model: rdy=%0b len=%0d data=%02h free=%0b err=%0b exp rdy=%0b len=%0d data=%02h free=%0b err=%0b",
                     cur, cpu_pkt_rdy, cpu_pkt_len, cpu_rd_data, sie_bank_free, cfg_err,
                     mrdy[mcb], elen, edat, !mrdy[msb], merr);
        end
    endtask

    task automatic expv(int act, int exp, string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cmp();
        cfg_wr = 0; cpu_clr = 0; sie_clr = 0; sie_wr_en = 0; sie_eop = 0; cpu_rd = 0;
    endtask

    task automatic send(int n, int base, bit eop);
        for (int i = 0; i < n; i++) begin
            sie_wr_en = 1; sie_wr_data = 8'(base + i); sie_eop = eop && (i == n - 1);
            tick();
        end
    endtask

    task automatic cfg(int size, int maxp, bit dbl, bit rc, bit disc);
        cfg_wr = 1; cfg_size = CNT_W'(size); cfg_maxpkt = CNT_W'(maxp);
        cfg_dbl = dbl; cfg_clr_after_rd = rc; cfg_discard = disc;
        tick();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur = "R1"; tick();
        expv(cpu_pkt_rdy, 0, "R1 rdy"); expv(cpu_pkt_len, 0, "R1 len");
        expv(sie_bank_free, 1, "R1 free"); expv(cfg_err, 0, "R1 err");

        cur = "R2"; send(3, 8'hA1, 1);
        expv(cpu_pkt_rdy, 1, "R2 rdy"); expv(cpu_pkt_len, 3, "R2 len");
        expv(cpu_rd_data, 8'hA1, "R2 first"); expv(sie_bank_free, 0, "R2 free");
        cpu_rd = 1; tick(); expv(cpu_rd_data, 8'hA2, "R2 second");
        cpu_rd = 1; tick(); cpu_rd = 1; tick();
        expv(cpu_rd_data, 0, "R2 past end"); expv(cpu_pkt_rdy, 1, "R2 still rdy");
        cur = "R4"; cpu_clr = 1; tick();
        expv(cpu_pkt_rdy, 0, "R4 rdy"); expv(cpu_pkt_len, 0, "R4 len");

        cur = "R3"; send(70, 0, 1); expv(cpu_pkt_len, 64, "R3 size cap");
        send(2, 0, 1); expv(cpu_pkt_len, 64, "R3 ready bank blocks");
        cpu_clr = 1; tick();

        cur = "R9"; cfg(8, 16, 1, 0, 0); expv(cfg_err, 1, "R9 small size");
        send(10, 0, 1); expv(cpu_pkt_len, 10, "R9 size unchanged");
        cpu_clr = 1; tick();
        cfg(100, 8, 0, 0, 0); expv(cfg_err, 1, "R9 oversize");
        cfg(8, 8, 1, 0, 0); expv(cfg_err, 0, "R9 good cfg");

        cur = "R8"; send(2, 8'h10, 1);
        expv(sie_bank_free, 1, "R8 second bank free");
        send(3, 8'h20, 1);
        expv(sie_bank_free, 0, "R8 both full"); expv(cpu_pkt_len, 2, "R8 first pkt");
        expv(cpu_rd_data, 8'h10, "R8 first data");
        cpu_clr = 1; tick();
        expv(cpu_pkt_len, 3, "R8 second pkt"); expv(cpu_rd_data, 8'h20, "R8 second data");
        cpu_clr = 1; tick(); expv(cpu_pkt_rdy, 0, "R8 drained");

        cur = "R5"; send(2, 8'h30, 1); send(3, 8'h40, 0);
        sie_clr = 1; tick();
        expv(cpu_pkt_len, 2, "R5 cpu bank kept"); expv(cpu_pkt_rdy, 1, "R5 cpu rdy kept");
        send(1, 8'h50, 1); cpu_clr = 1; tick();
        expv(cpu_pkt_len, 1, "R5 partial dropped");
        cpu_clr = 1; tick();

        cur = "R10"; cfg(64, 8, 0, 0, 0); send(2, 0, 0);
        expv(cpu_pkt_len, 2, "R10 partial");
        sie_wr_en = 1; sie_clr = 1; tick(); expv(cpu_pkt_len, 0, "R10 sie clr wins");
        send(2, 0, 0); sie_wr_en = 1; sie_eop = 1; cpu_clr = 1; tick();
        expv(cpu_pkt_len, 0, "R10 cpu clr wins"); expv(cpu_pkt_rdy, 0, "R10 eop dropped");

        cur = "R6"; cfg(16, 8, 0, 1, 0); send(2, 8'h60, 1);
        cpu_rd = 1; tick(); expv(cpu_rd_data, 8'h61, "R6 mid");
        cpu_rd = 1; tick();
        expv(cpu_pkt_rdy, 0, "R6 auto rdy"); expv(cpu_pkt_len, 0, "R6 auto len");

        cur = "R7"; cfg(16, 8, 1, 0, 1); send(3, 8'h70, 1);
        expv(cpu_pkt_rdy, 0, "R7 rdy"); expv(cpu_pkt_len, 0, "R7 len");
        expv(sie_bank_free, 1, "R7 free");

        cur = "RND R2 R3 R4 R5 R6 R8 R9 R10";
        for (int n = 0; n < 4000; n++) begin
            sie_wr_en = ($urandom % 3) != 0; sie_wr_data = 8'($urandom);
            sie_eop = ($urandom % 8) == 0; cpu_rd = $urandom % 2;
            cpu_clr = ($urandom % 25) == 0; sie_clr = ($urandom % 30) == 0;
            if (($urandom % 60) == 0) begin
                cfg_wr = 1; cfg_size = CNT_W'($urandom_range(0, 70));
                cfg_maxpkt = CNT_W'($urandom_range(0, 40));
                cfg_dbl = $urandom % 2; cfg_clr_after_rd = $urandom % 2;
                cfg_discard = ($urandom % 5) == 0;
            end
            tick();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule